// File: doc/BRIEF.md
# Raster Video and Sound DMA Scheduler

This block divides a 16 MHz system clock into one shared-memory slot per microsecond and decides, slot by slot, who owns the DRAM. In each slot, the owner is one of three: a fetch of one bitmap word for a 512 x 342 monochrome screen, a fetch of one sound/PWM sample, or the processor. Each scan line is 44 slots long. The first 32 slots of a visible line fetch screen words. The last slot of every line fetches a sound sample. The slots in between are horizontal retrace and go to the processor. The lines after the visible ones form the vertical retrace. On those lines no screen words are fetched, and only the per-line sound slot is taken.

The block drives horizontal sync, vertical sync, a blanking flag, the fetch address, a flag that marks an alternate-buffer fetch, and a processor-grant flag. Two page-select inputs are active low. A 1 picks the main buffer and a 0 picks the alternate buffer. The screen page is sampled only at the frame boundary, so a frame never mixes two pages. The sound page is used as it stands in each sound slot. Each fetched screen word is loaded into a 16-bit register and shifted out one pixel per system clock, with the most significant bit first. An asynchronous reset puts every counter at line 0, slot 0, so the phase of the timing is fixed without any calibration.

Top module: `raster_dma_sched`

## Requirements
- R1: `cpu_clk_o` toggles on every system clock, which divides the clock by 2. `slot_clk_o` is high in the second half of each slot. A slot lasts WORD_W = 16 system clocks, so `slot_clk_o` divides the clock by 16.
- R2: A line holds SLOTS = 44 slots, numbered 0 to 43. On a visible line, slots 0 to ACTIVE_SLOTS-1 (0 to 31) are screen fetches. For those slots `slot_kind_o` = 1 (video) and `blank_o` = 0.
- R3: Slot 43 of every line, whether visible or retrace, is a sound fetch with `slot_kind_o` = 2.
- R4: Every other slot belongs to the processor, with `slot_kind_o` = 0. This includes slots 0 to 42 of every retrace line. `cpu_grant_o` is 1 exactly when `slot_kind_o` = 0.
- R5: `hsync_o` is 1 in slots HSYNC_START (41) to 43 of every line, and 0 in all other slots.
- R6: A frame has TOTAL_LINES lines, of which the first ACTIVE_LINES are visible. `vsync_o` is 1 on lines ACTIVE_LINES to ACTIVE_LINES+VSYNC_LINES-1. `blank_o` is 1 in every slot that is not a screen fetch.
- R7: In a screen slot, `fetch_addr_o` equals the screen base plus a word offset. The offset starts at 0 at line 0, slot 0, rises by one per screen slot across lines, and returns to 0 at the frame boundary. In processor slots, `fetch_addr_o` is 0.
- R8: `scr_sel_n_i` is sampled only when the frame wraps. A 1 selects SCR_MAIN_BASE and a 0 selects SCR_ALT_BASE. A change in mid-frame has no effect until the next frame. In screen slots, `buf_alt_o` shows the page in use.
- R9: In a sound slot, `fetch_addr_o` equals the sound base plus the line number. `snd_sel_n_i` = 1 selects SND_MAIN_BASE and 0 selects SND_ALT_BASE, taken from the input as it stands at that time. `buf_alt_o` is 1 for the alternate sound buffer.
- R10: `vid_word_i` is loaded on the last clock of each screen slot. During the 16 clocks of the following slot, `pixel_o` shows bits 15 down to 0 in turn. When no word was loaded, `pixel_o` is 0.
- R11: While `rst_n` is 0, the block sits at line 0, slot 0, phase 0 with the main screen page. It shows a video slot at SCR_MAIN_BASE, with `buf_alt_o`, `hsync_o`, `vsync_o`, `blank_o`, `pixel_o` and both clock outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scr_sel_n_i | input | 1 | Screen page select, active low (1 = main) |
| snd_sel_n_i | input | 1 | Sound page select, active low (1 = main) |
| vid_word_i | input | WORD_W | Screen word returned by memory |
| cpu_clk_o | output | 1 | System clock divided by 2 |
| slot_clk_o | output | 1 | Slot clock, system clock divided by WORD_W |
| slot_kind_o | output | 2 | Owner of the slot: 0 = processor, 1 = video, 2 = sound |
| cpu_grant_o | output | 1 | Slot granted to the processor |
| fetch_addr_o | output | ADDR_W | Word address of the current fetch |
| buf_alt_o | output | 1 | Current fetch uses the alternate buffer |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Blanking flag |
| pixel_o | output | 1 | Serial pixel out |

## Verification
The bench keeps the full 44-slot line and the 16-bit word, but shrinks the frame to 7 lines. Four lines are visible and two carry vertical sync. Distinct bases are set for the four buffers, 0x1000, 0x2000, 0x3000 and 0x4000. With these values a frame lasts under 5000 clocks. The bench can therefore reach several frame wraps: the screen page sampled at a wrap, the address continuing across lines, the sound address tracking the line number, and a sweep of every slot of a complete frame, all within a short run.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef enum logic [1:0] {
    KIND_CPU   = 2'd0,
    KIND_VIDEO = 2'd1,
    KIND_SOUND = 2'd2
  } slot_kind_e;

endpackage

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int WORD_W      = 16,
  parameter int SLOTS       = 44,
  parameter int TOTAL_LINES = 370,
  parameter int PH_W        = 4,
  parameter int SLOT_W      = 6,
  parameter int LINE_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PH_W-1:0]   phase_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [LINE_W-1:0] line_q,
  output logic              phase_last_o,
  output logic              frame_end_o
);

  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(TOTAL_LINES - 1);

  logic              phase_last, slot_last, line_last;
  logic              slot_en, line_en;
  logic [PH_W-1:0]   phase_d;
  logic [SLOT_W-1:0] slot_d;
  logic [LINE_W-1:0] line_d;

  always_comb begin
    phase_last = (phase_q == PH_LAST);
    slot_last  = (slot_q == SLOT_LAST);
    line_last  = (line_q == LINE_LAST);
    slot_en    = phase_last;
    line_en    = phase_last & slot_last;
    phase_d    = phase_last ? '0 : phase_q + 1'b1;
    slot_d     = slot_last ? '0 : slot_q + 1'b1;
    line_d     = line_last ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
      line_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (slot_en) slot_q <= slot_d;
      if (line_en) line_q <= line_d;
    end
  end

  assign phase_last_o = phase_last;
  assign frame_end_o  = line_en & line_last;

endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int SLOTS        = 44,
  parameter int ACTIVE_SLOTS = 32,
  parameter int HSYNC_START  = 41,
  parameter int ACTIVE_LINES = 342,
  parameter int VSYNC_LINES  = 4,
  parameter int SLOT_W       = 6,
  parameter int LINE_W       = 9
) (
  input  logic [SLOT_W-1:0] slot_q,
  input  logic [LINE_W-1:0] line_q,
  output slot_kind_e        kind_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o
);

  localparam logic [SLOT_W-1:0] SLOT_ACT  = SLOT_W'(ACTIVE_SLOTS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] HS_FIRST  = SLOT_W'(HSYNC_START);
  localparam logic [LINE_W-1:0] LINE_ACT  = LINE_W'(ACTIVE_LINES);
  localparam logic [LINE_W-1:0] VS_END    = LINE_W'(ACTIVE_LINES + VSYNC_LINES);

  logic visible;

  always_comb begin
    visible = (line_q < LINE_ACT) && (slot_q < SLOT_ACT);
    if (slot_q == SLOT_LAST) kind_o = KIND_SOUND;
    else if (visible)        kind_o = KIND_VIDEO;
    else                     kind_o = KIND_CPU;
    hsync_o = (slot_q >= HS_FIRST);
    vsync_o = (line_q >= LINE_ACT) && (line_q < VS_END);
    blank_o = !visible;
  end

endmodule

// File: rtl/raster_addr.sv
module raster_addr
  import raster_pkg::*;
#(
  parameter int          ADDR_W        = 24,
  parameter int          LINE_W        = 9,
  parameter logic [23:0] SCR_MAIN_BASE = 24'h03_A700,
  parameter logic [23:0] SCR_ALT_BASE  = 24'h03_2700,
  parameter logic [23:0] SND_MAIN_BASE = 24'h03_FD00,
  parameter logic [23:0] SND_ALT_BASE  = 24'h03_A100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_kind_e        kind_i,
  input  logic              phase_last_i,
  input  logic              frame_end_i,
  input  logic              scr_sel_n_i,
  input  logic              snd_sel_n_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              alt_o
);

  logic [ADDR_W-1:0] voff_q, voff_d;
  logic              scr_alt_q, scr_alt_d;
  logic              step_en;
  logic [ADDR_W-1:0] scr_base, snd_base;

  always_comb begin
    step_en   = phase_last_i && (kind_i == KIND_VIDEO);
    voff_d    = voff_q;
    scr_alt_d = scr_alt_q;
    if (frame_end_i) begin
      voff_d    = '0;
      scr_alt_d = ~scr_sel_n_i;
    end else if (step_en) begin
      voff_d    = voff_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      voff_q    <= '0;
      scr_alt_q <= 1'b0;
    end else begin
      voff_q    <= voff_d;
      scr_alt_q <= scr_alt_d;
    end
  end

  always_comb begin
    scr_base = scr_alt_q   ? ADDR_W'(SCR_ALT_BASE)  : ADDR_W'(SCR_MAIN_BASE);
    snd_base = snd_sel_n_i ? ADDR_W'(SND_MAIN_BASE) : ADDR_W'(SND_ALT_BASE);
    case (kind_i)
      KIND_VIDEO: begin
        addr_o = scr_base + voff_q;
        alt_o  = scr_alt_q;
      end
      KIND_SOUND: begin
        addr_o = snd_base + ADDR_W'(line_i);
        alt_o  = ~snd_sel_n_i;
      end
      default: begin
        addr_o = '0;
        alt_o  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/raster_shifter.sv
module raster_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              pixel_o
);

  logic [WORD_W-1:0] sr_q, sr_d;

  always_comb begin
    if (load_i) sr_d = word_i;
    else        sr_d = {sr_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign pixel_o = sr_q[WORD_W-1];

endmodule

// File: rtl/raster_dma_sched.sv
module raster_dma_sched
  import raster_pkg::*;
#(
  parameter int          WORD_W        = 16,
  parameter int          SLOTS         = 44,
  parameter int          ACTIVE_SLOTS  = 32,
  parameter int          HSYNC_START   = 41,
  parameter int          ACTIVE_LINES  = 342,
  parameter int          TOTAL_LINES   = 370,
  parameter int          VSYNC_LINES   = 4,
  parameter int          ADDR_W        = 24,
  parameter logic [23:0] SCR_MAIN_BASE = 24'h03_A700,
  parameter logic [23:0] SCR_ALT_BASE  = 24'h03_2700,
  parameter logic [23:0] SND_MAIN_BASE = 24'h03_FD00,
  parameter logic [23:0] SND_ALT_BASE  = 24'h03_A100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scr_sel_n_i,
  input  logic              snd_sel_n_i,
  input  logic [WORD_W-1:0] vid_word_i,
  output logic              cpu_clk_o,
  output logic              slot_clk_o,
  output logic [1:0]        slot_kind_o,
  output logic              cpu_grant_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              buf_alt_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o,
  output logic              pixel_o
);

  localparam int PH_W   = $clog2(WORD_W);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LINE_W = $clog2(TOTAL_LINES);

  logic [PH_W-1:0]   phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LINE_W-1:0] line_q;
  logic              phase_last, frame_end;
  slot_kind_e        kind;
  logic              load_en;

  raster_counters #(
    .WORD_W(WORD_W), .SLOTS(SLOTS), .TOTAL_LINES(TOTAL_LINES),
    .PH_W(PH_W), .SLOT_W(SLOT_W), .LINE_W(LINE_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .phase_q(phase_q), .slot_q(slot_q), .line_q(line_q),
    .phase_last_o(phase_last), .frame_end_o(frame_end)
  );

  raster_decode #(
    .SLOTS(SLOTS), .ACTIVE_SLOTS(ACTIVE_SLOTS), .HSYNC_START(HSYNC_START),
    .ACTIVE_LINES(ACTIVE_LINES), .VSYNC_LINES(VSYNC_LINES),
    .SLOT_W(SLOT_W), .LINE_W(LINE_W)
  ) u_dec (
    .slot_q(slot_q), .line_q(line_q), .kind_o(kind),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o)
  );

  raster_addr #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W),
    .SCR_MAIN_BASE(SCR_MAIN_BASE), .SCR_ALT_BASE(SCR_ALT_BASE),
    .SND_MAIN_BASE(SND_MAIN_BASE), .SND_ALT_BASE(SND_ALT_BASE)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .kind_i(kind),
    .phase_last_i(phase_last), .frame_end_i(frame_end),
    .scr_sel_n_i(scr_sel_n_i), .snd_sel_n_i(snd_sel_n_i),
    .line_i(line_q), .addr_o(fetch_addr_o), .alt_o(buf_alt_o)
  );

  assign load_en = phase_last && (kind == KIND_VIDEO);

  raster_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load_i(load_en),
    .word_i(vid_word_i), .pixel_o(pixel_o)
  );

  assign cpu_clk_o   = phase_q[0];
  assign slot_clk_o  = phase_q[PH_W-1];
  assign slot_kind_o = kind;
  assign cpu_grant_o = (kind == KIND_CPU);

endmodule

// File: rtl/raster_dma_sched_chk.sv
module raster_dma_sched_chk #(
  parameter int SLOTS       = 44,
  parameter int TOTAL_LINES = 370,
  parameter int PH_W        = 4,
  parameter int SLOT_W      = 6,
  parameter int LINE_W      = 9,
  parameter int ADDR_W      = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PH_W-1:0]   phase_q,
  input logic [SLOT_W-1:0] slot_q,
  input logic [LINE_W-1:0] line_q,
  input logic [1:0]        slot_kind_o,
  input logic              cpu_grant_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              blank_o
);

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != '0) |-> (phase_q == $past(phase_q) + 1'b1)); // R1

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) < SLOTS); // R2

  AST_SOUND_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kind_o == 2'd2) |-> (int'(slot_q) == SLOTS - 1)); // R3

  AST_GRANT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_grant_o |-> (fetch_addr_o == '0)); // R4

  AST_HSYNC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_o |-> blank_o); // R5

  AST_VSYNC_NO_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_o |-> (slot_kind_o != 2'd1)); // R6

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line_q) < TOTAL_LINES); // R6

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_kind_o == 2'd1) && (phase_q != '0)) |-> $stable(fetch_addr_o)); // R7

endmodule

bind raster_dma_sched raster_dma_sched_chk #(
  .SLOTS(SLOTS), .TOTAL_LINES(TOTAL_LINES),
  .PH_W(PH_W), .SLOT_W(SLOT_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .slot_q(slot_q),
  .line_q(line_q), .slot_kind_o(slot_kind_o), .cpu_grant_o(cpu_grant_o),
  .fetch_addr_o(fetch_addr_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .blank_o(blank_o)
);

// File: tb/raster_dma_sched_tb.sv
`timescale 1ns/1ps
module raster_dma_sched_tb;

  localparam int LINE_CLK = 44 * 16;
  localparam int FRAME    = 7 * LINE_CLK;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scr_sel_n, snd_sel_n;
  logic [15:0] vid_word;
  logic        cpu_clk, slot_clk, grant, alt, hs, vs, blank, pixel;
  logic [1:0]  kind;
  logic [23:0] addr;

  int n_chk = 0;
  int n_bad = 0;
  int ncyc;
  bit done = 0;

  always #2 clk = ~clk;

  raster_dma_sched #(
    .WORD_W(16), .SLOTS(44), .ACTIVE_SLOTS(32), .HSYNC_START(41),
    .ACTIVE_LINES(4), .TOTAL_LINES(7), .VSYNC_LINES(2), .ADDR_W(24),
    .SCR_MAIN_BASE(24'h001000), .SCR_ALT_BASE(24'h002000),
    .SND_MAIN_BASE(24'h003000), .SND_ALT_BASE(24'h004000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scr_sel_n_i(scr_sel_n), .snd_sel_n_i(snd_sel_n),
    .vid_word_i(vid_word), .cpu_clk_o(cpu_clk), .slot_clk_o(slot_clk),
    .slot_kind_o(kind), .cpu_grant_o(grant), .fetch_addr_o(addr),
    .buf_alt_o(alt), .hsync_o(hs), .vsync_o(vs), .blank_o(blank), .pixel_o(pixel)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, ncyc, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (ncyc < n) @(negedge clk);
  endtask

  function automatic logic [31:0] flags();
    return {26'd0, kind, grant, hs, vs, blank};
  endfunction

  // entry: cycle[15:0] kind[1:0] grant hs vs blank addr[23:0] alt
  localparam int NV = 11;
  localparam logic [46:0] TBL [NV] = '{
    {16'd0,    2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 24'h001000, 1'b0},
    {16'd501,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 24'h00101F, 1'b0},
    {16'd512,  2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 24'h000000, 1'b0},
    {16'd656,  2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 24'h000000, 1'b0},
    {16'd688,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 24'h003000, 1'b0},
    {16'd759,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 24'h001023, 1'b0},
    {16'd2608, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 24'h00107F, 1'b0},
    {16'd2816, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 24'h000000, 1'b0},
    {16'd3504, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 24'h003004, 1'b0},
    {16'd4000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 24'h000000, 1'b0},
    {16'd4304, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 24'h000000, 1'b0}
  };

  task automatic check_reset_state();
    chk("R11", "kind in reset", {30'd0, kind}, 32'd1);
    chk("R11", "addr in reset", {8'd0, addr}, 32'h1000);
    chk("R11", "alt/hs/vs/blank/pixel in reset",
        {27'd0, alt, hs, vs, blank, pixel}, 32'd0);
    chk("R11", "clocks in reset", {30'd0, cpu_clk, slot_clk}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; scr_sel_n = 1'b1; snd_sel_n = 1'b1; vid_word = 16'h0000;
    repeat (3) @(negedge clk);
    check_reset_state();
    scr_sel_n = 1'b0;  // ignored until the frame wraps (R8)
    rst_n = 1'b1;

    // table walk over frame 0: R2..R7, R8 mid-frame change ignored
    for (int i = 0; i < NV; i++) begin
      wait_to(int'(TBL[i][46:31]));
      chk("R2_R3_R4_R5_R6", "kind/grant/hs/vs/blank", flags(),
          {26'd0, TBL[i][30:25]});
      chk("R7_R8_R9", "fetch address", {8'd0, addr}, {8'd0, TBL[i][24:1]});
      chk("R8", "buffer flag", {31'd0, alt}, {31'd0, TBL[i][0]});
    end

    // frame wrap picks the alternate screen page
    wait_to(FRAME);
    chk("R8", "alt page addr after wrap", {8'd0, addr}, 32'h2000);
    chk("R8", "alt page flag after wrap", {31'd0, alt}, 32'd1);
    wait_to(FRAME + 3);
    chk("R1", "cpu_clk high on odd cycle", {31'd0, cpu_clk}, 32'd1);
    chk("R1", "slot_clk low in first half", {31'd0, slot_clk}, 32'd0);
    wait_to(FRAME + 8);
    chk("R1", "cpu_clk low on even cycle", {31'd0, cpu_clk}, 32'd0);
    chk("R1", "slot_clk high in second half", {31'd0, slot_clk}, 32'd1);
    chk("R1", "grant/kind steady through slot", flags(), {26'd0, 2'd1, 4'b0000});
    snd_sel_n = 1'b0;
    wait_to(FRAME + 688);
    chk("R9", "alt sound addr line 0", {8'd0, addr}, 32'h4000);
    chk("R9", "alt sound flag", {31'd0, alt}, 32'd1);
    wait_to(FRAME + 2 * LINE_CLK + 688);
    chk("R9", "alt sound addr line 2", {8'd0, addr}, 32'h4002);
    snd_sel_n = 1'b1;
    wait_to(FRAME + 3 * LINE_CLK + 688);
    chk("R9", "main sound addr line 3", {8'd0, addr}, 32'h3003);
    chk("R9", "main sound flag", {31'd0, alt}, 32'd0);

    // mid-line reset with alternate page latched and select still 0
    wait_to(FRAME + 3 * LINE_CLK + 700);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();

    // shifter: word loaded at the end of slot 0 appears in slot 1
    vid_word = 16'hA5C3;
    rst_n = 1'b1;
    wait_to(8);
    chk("R10", "pixel before first load", {31'd0, pixel}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      wait_to(16 + k);
      chk("R10", "serial pixel MSB first", {31'd0, pixel},
          {31'd0, vid_word[15 - k]});
    end
    wait_to(16 * 33 + 3);
    chk("R10", "pixel after processor slot", {31'd0, pixel}, 32'd0);
    chk("R11", "addr main after reset", {8'd0, addr}, 32'h0);

    // full-frame sweep of every slot of frame 1
    for (int ln = 0; ln < 7; ln++) begin
      for (int sl = 0; sl < 44; sl++) begin
        logic [1:0] ek;
        logic       ehs, evs, ebl;
        ek  = (sl == 43) ? 2'd2 : ((ln < 4 && sl < 32) ? 2'd1 : 2'd0);
        ehs = (sl >= 41);
        evs = (ln == 4 || ln == 5);
        ebl = (ek != 2'd1);
        wait_to(FRAME + ln * LINE_CLK + sl * 16 + 8);
        chk("R2_R3_R4_R5_R6", "sweep flags", flags(),
            {26'd0, ek, (ek == 2'd0), ehs, evs, ebl});
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule